// File: doc/BRIEF.md
# Three-Channel Buffered PWM Generator

This block produces three pulse-width-modulated outputs from one shared 10-bit up-counter. The counter advances once per timer tick and restarts at zero after it reaches the active period value. Each channel compares the counter with its own active duty value. The channel holds its active level from the start of the period while the counter is at or below that duty value. A per-channel polarity bit picks which level counts as active.

Software programs the block through a byte-wide write port. Period and duty writes land in holding buffers. The live values normally take the buffered contents only when the counter wraps, so a period that has already started always runs to its end with consistent values. A control bit requests an immediate transfer instead. That request crosses a three-stage synchronizer clocked by the timer tick, so it lands a fixed three ticks after the write. The bit then clears itself.

Top module: `pwm3_dbuf`

## Requirements
- R1: The counter runs from 0 up to the active period value P and then returns to 0, so one output period is P+1 ticks. When P is lowered below the current count, the counter returns to 0 on the next tick.
- R2: A channel with duty value D (D < P) is active for exactly D+1 ticks, starting at count 0, and inactive for the rest of the period.
- R3: Each 10-bit value is written as two bytes. The low byte goes to the even address and bits 1:0 of the data go to the odd address. Period uses addresses 0/1, and channel k (A=0, B=1, C=2) uses addresses 2+2k and 3+2k. Address 8 is control: bit 0 enable, bit 1 immediate update, bit 2+k polarity of channel k.
- R4: Writes to period or duty buffers do not change the running waveform. The buffered values become active at the tick on which the counter wraps, so the next period uses them.
- R5: Writing control with bit 1 set copies all buffers to the active registers at the third tick after the write, without waiting for the wrap.
- R6: The update bit clears itself when the immediate transfer completes. Buffer writes made afterwards again wait for the wrap.
- R7: With polarity 1 the active level is high. With polarity 0 it is low and the waveform is inverted.
- R8: The three channels share the period and counter but use independent duty values and polarities.
- R9: A duty value at or above the period keeps the channel at its active level for the whole period. A duty of 0 gives a one-tick pulse.
- R10: While enable is 0, the counter is held at 0 and every output sits at its inactive level. After enable is set, the first active run starts immediately at count 0. Reset clears all buffers, active values and control bits, so every output is high after reset.
- R11: The counter and synchronizer advance only on cycles where the tick input is 1. At half tick rate, every duration doubles in clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer tick enable from an external prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 3 | PWM outputs, bit k is channel k |

## Verification
The bench shortens the period from 14 to 10 in the middle of a period. A design that loaded the period on the write instead of at the wrap would cut the current period short. It also times an immediate duty change against the three-tick latency: an off-by-one synchronizer moves the falling edge by a cycle. After an immediate update completes, a buffer write must not reach the output before the wrap; a sticky update bit would apply it within three ticks. Other checks cover a duty above the period, a duty of zero, inverted polarity, the held counter on enable, and half-rate ticks, which expose any counting on the clock instead of the tick.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int ARG_W = 16;

  // channel active while the count has not passed the duty value
  function automatic logic in_duty(input logic [ARG_W-1:0] cnt, input logic [ARG_W-1:0] duty);
    return cnt <= duty;
  endfunction

  // end of period reached (also covers a period lowered below the count)
  function automatic logic at_end(input logic [ARG_W-1:0] cnt, input logic [ARG_W-1:0] per);
    return cnt >= per;
  endfunction
endpackage

// File: rtl/pwm3_regfile.sv
module pwm3_regfile #(
  parameter int CNT_W  = 10,
  parameter int LO_W   = 8,
  parameter int NCH    = 3,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [LO_W-1:0]            wr_data,
  input  logic                       sync_done,
  output logic [CNT_W-1:0]           per_buf,
  output logic [NCH-1:0][CNT_W-1:0]  dty_buf,
  output logic                       en,
  output logic [NCH-1:0]             pol,
  output logic                       upd
);
  localparam int HI_W      = CNT_W - LO_W;
  localparam int CTRL_ADDR = 2 + 2 * NCH;

  logic ctrl_wr;
  logic ctrl_upd_wr;
  assign ctrl_wr     = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  assign ctrl_upd_wr = ctrl_wr && wr_data[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_buf <= '0;
      dty_buf <= '0;
      en      <= 1'b0;
      pol     <= '0;
      upd     <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADDR_W'(0)) per_buf[LO_W-1:0]     <= wr_data;
      if (wr_en && wr_addr == ADDR_W'(1)) per_buf[CNT_W-1:LO_W] <= wr_data[HI_W-1:0];
      for (int k = 0; k < NCH; k++) begin
        if (wr_en && wr_addr == ADDR_W'(2 + 2 * k)) dty_buf[k][LO_W-1:0]     <= wr_data;
        if (wr_en && wr_addr == ADDR_W'(3 + 2 * k)) dty_buf[k][CNT_W-1:LO_W] <= wr_data[HI_W-1:0];
      end
      if (ctrl_wr) begin
        en  <= wr_data[0];
        pol <= wr_data[2 +: NCH];
      end
      // a new request wins over the completion clearing it
      if (ctrl_upd_wr)    upd <= 1'b1;
      else if (sync_done) upd <= 1'b0;
    end
  end

  // R6: update bit self-clears once the transfer lands
  p_upd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done && !ctrl_upd_wr |=> !upd);
endmodule

// File: rtl/pwm3_sync.sv
module pwm3_sync #(
  parameter int SYNC_STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic req,
  output logic done
);
  localparam int SW = SYNC_STAGES - 1;

  logic [SW-1:0] stg;
  logic          start;

  assign start = req && (stg == '0);
  assign done  = tick && stg[SW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg <= '0;
    end else if (tick) begin
      stg[0] <= start;
      for (int i = 1; i < SW; i++) stg[i] <= stg[i-1];
    end
  end

  // R5: a transfer only completes for a pending request
  p_done_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req);
endmodule

// File: rtl/pwm3_counter.sv
module pwm3_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic [CNT_W-1:0] per_act,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  import pwm3_pkg::*;

  assign wrap = tick && en && at_end(ARG_W'(cnt), ARG_W'(per_act));

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (!en)   cnt <= '0;
    else if (wrap)  cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  // R1: the count restarts after a wrap
  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);
  // R10: disabled counter sits at zero
  p_hold_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == '0);
  // R11: no tick, no movement
  p_no_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    en && !tick |=> $stable(cnt));
endmodule

// File: rtl/pwm3_channel.sv
module pwm3_channel #(
  parameter int CNT_W = 10
) (
  input  logic             en,
  input  logic             pol,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty,
  output logic             out
);
  import pwm3_pkg::*;

  logic active;
  assign active = en && in_duty(ARG_W'(cnt), ARG_W'(duty));
  assign out    = active ? pol : ~pol;
endmodule

// File: rtl/pwm3_dbuf.sv
module pwm3_dbuf #(
  parameter int CNT_W       = 10,
  parameter int LO_W        = 8,
  parameter int NCH         = 3,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LO_W-1:0]   wr_data,
  output logic [NCH-1:0]    pwm_out
);
  logic [CNT_W-1:0]          per_buf, per_act;
  logic [NCH-1:0][CNT_W-1:0] dty_buf, dty_act;
  logic                      en, upd, sync_done, wrap;
  logic [NCH-1:0]            pol;
  logic [CNT_W-1:0]          cnt;
  logic                      load_evt;

  pwm3_regfile #(.CNT_W(CNT_W), .LO_W(LO_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_done(sync_done), .per_buf(per_buf), .dty_buf(dty_buf),
    .en(en), .pol(pol), .upd(upd)
  );

  pwm3_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req(upd), .done(sync_done)
  );

  pwm3_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .per_act(per_act),
    .cnt(cnt), .wrap(wrap)
  );

  // live registers take the buffers at the wrap or on an immediate transfer
  assign load_evt = wrap || sync_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_act <= '0;
      dty_act <= '0;
    end else if (load_evt) begin
      per_act <= per_buf;
      dty_act <= dty_buf;
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    pwm3_channel #(.CNT_W(CNT_W)) u_ch (
      .en(en), .pol(pol[k]), .cnt(cnt), .duty(dty_act[k]), .out(pwm_out[k])
    );
  end

  // R4: live period never moves without a load event
  p_act_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(per_act));
endmodule

// File: tb/tb_pwm3_dbuf.sv
module tb_pwm3_dbuf;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  // {period, dutyA, dutyB, dutyC, pol[2:0]}
  localparam logic [42:0] VEC [NV] = '{
    {10'd14,   10'd5,   10'd0, 10'd9, 3'b111},
    {10'd10,   10'd3,   10'd7, 10'd2, 3'b101},
    {10'd1023, 10'd128, 10'd1, 10'd0, 3'b110},
    {10'd3,    10'd0,   10'd1, 10'd2, 3'b000}
  };

  logic clk = 0, rst_n = 0, tick = 1, half = 0;
  logic wr_en = 0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] pwm_out;
  int checks = 0, errors = 0;

  pwm3_dbuf dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
                 .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) tick <= half ? ~tick : 1'b1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic cfg(input logic [9:0] p, input logic [9:0] da, input logic [9:0] db,
                     input logic [9:0] dc, input logic [2:0] pl);
    wr(0, p[7:0]);  wr(1, {6'd0, p[9:8]});
    wr(2, da[7:0]); wr(3, {6'd0, da[9:8]});
    wr(4, db[7:0]); wr(5, {6'd0, db[9:8]});
    wr(6, dc[7:0]); wr(7, {6'd0, dc[9:8]});
    wr(8, {3'd0, pl, 2'b10});
    repeat (10) @(negedge clk);
    wr(8, {3'd0, pl, 2'b01});
  endtask

  // wait for the start of a period, then time active run and full period
  task automatic measure(input int ch, input logic lvl, output int act, output int tot);
    int n;
    act = 0; tot = 0;
    n = 0; while (pwm_out[ch] == lvl && n < 5000) begin @(negedge clk); n++; end
    n = 0; while (pwm_out[ch] != lvl && n < 5000) begin @(negedge clk); n++; end
    while (pwm_out[ch] == lvl && act < 5000) begin act++; @(negedge clk); end
    tot = act;
    while (pwm_out[ch] != lvl && tot < 5000) begin tot++; @(negedge clk); end
  endtask

  task automatic to_next_start(input int ch, input logic lvl, output int n);
    logic seen;
    seen = 0; n = 0;
    while (n < 5000) begin
      @(negedge clk); n++;
      if (pwm_out[ch] != lvl) seen = 1;
      else if (seen) break;
    end
  endtask

  task automatic wait_rise(input int ch);
    int n;
    n = 0; while (pwm_out[ch] == 1'b1 && n < 5000) begin @(negedge clk); n++; end
    n = 0; while (pwm_out[ch] == 1'b0 && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a, t, n, hi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset outputs high", int'(pwm_out), 7);

    // R1 R2 R3 R7 R8 R9: table of settings, every channel timed
    for (int v = 0; v < NV; v++) begin
      logic [9:0] p;
      p = VEC[v][42:33];
      cfg(p, VEC[v][32:23], VEC[v][22:13], VEC[v][12:3], VEC[v][2:0]);
      for (int ch = 0; ch < 3; ch++) begin
        logic [9:0] d;
        d = VEC[v][32 - 10*ch -: 10];
        measure(ch, VEC[v][ch], a, t);
        chk("R2 R7 R8 active run", a, int'(d) + 1);
        chk("R1 R3 period", t, int'(p) + 1);
      end
    end

    // R10: disabled hold, then first run begins at count 0
    cfg(10'd14, 10'd5, 10'd0, 10'd9, 3'b111);
    wr(8, 8'b000_111_00);
    repeat (20) @(negedge clk);
    chk("R10 disabled outputs inactive", int'(pwm_out), 0);
    wr(8, 8'b000_111_01);
    hi = 0;
    while (pwm_out[0] && hi < 100) begin hi++; @(negedge clk); end
    chk("R10 first run after enable", hi, 6);

    // R4: period 14 -> 10 written mid-period finishes the old period
    wait_rise(0);
    wr(0, 8'h0A);
    to_next_start(0, 1'b1, n);
    chk("R4 old period completes", n, 14);
    measure(0, 1'b1, a, t);
    chk("R4 new period after wrap", t, 11);
    chk("R4 duty kept", a, 6);

    // R5: immediate period 10 -> 14
    wait_rise(0);
    wr(0, 8'h0E);
    wr(8, 8'b000_111_11);
    to_next_start(0, 1'b1, n);
    chk("R5 immediate period", n, 13);

    // R5: immediate duty change lands three ticks after the control write
    wait_rise(0);
    hi = 1;
    wr(2, 8'd1);
    if (pwm_out[0]) hi++;
    wr(8, 8'b000_111_11);
    if (pwm_out[0]) hi++;
    @(negedge clk);
    while (pwm_out[0] && hi < 100) begin hi++; @(negedge clk); end
    chk("R5 three tick latency", hi, 5);

    // R6: update bit cleared, a later buffer write waits for the wrap
    wait_rise(0);
    wr(2, 8'd9);
    repeat (7) @(negedge clk);
    chk("R6 buffer not applied mid-period", int'(pwm_out[0]), 0);
    measure(0, 1'b1, a, t);
    chk("R6 applied after wrap", a, 10);

    // R9: duty above period stays active
    cfg(10'd14, 10'd5, 10'd0, 10'd20, 3'b111);
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      if (pwm_out[2]) hi++;
      @(negedge clk);
    end
    chk("R9 duty above period always active", hi, 40);

    // R10: disable mid-run forces inactive levels
    wr(8, 8'b000_111_00);
    chk("R10 disable mid-run", int'(pwm_out), 0);

    // R11: half-rate tick doubles every duration
    half = 1;
    cfg(10'd14, 10'd5, 10'd0, 10'd9, 3'b111);
    measure(0, 1'b1, a, t);
    chk("R11 half tick active", a, 12);
    chk("R11 half tick period", t, 30);
    half = 0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule